// File: doc/BRIEF.md
# USB Host Microframe Index Counter

This block keeps the host controller's running count of high-speed microframes and 1 ms frames. It is used for periodic scheduling. A 14-bit index register holds the microframe number in its low three bits and a frame count in its upper eleven bits. That index selects the entry of the periodic frame list that the schedule walker reads.

A second frame count feeds the frame-number field of every start-of-frame token. It deliberately runs one microframe behind the index. As a result, a schedule frame opens one microframe before the matching bus frame, and split transactions never straddle a frame wrap.

A small run/halt state machine gates two things. It lets each 125 us tick through only while running, and it lets software load a new index only while halted. Each accepted tick raises a one-cycle SOF request, delivers the lagged frame number, and advances the index.

Top module: `mfi_counter_top`

## Requirements
- R1: After reset the index is 0, the SOF frame number is 0x7FF (the frame of index minus one), no SOF request is raised and the block is halted.
- R2: A tick accepted while running advances the 14-bit index by one. Bits [2:0] count microframes 0 to 7, bits [13:3] count frames, and 0x3FFF wraps to 0.
- R3: An accepted tick raises `sof_req_o` for exactly one cycle, in the cycle after the tick edge. The new index and the new SOF number appear in that same cycle.
- R4: The SOF frame number always equals bits [13:3] of (index − 1) modulo 2^14. Each SOF therefore carries the frame that the index held one microframe earlier.
- R5: The frame list offset equals index bits [12:3] times 4 (a 12-bit byte offset into a 1024-entry list). It is taken from the index, not from the SOF number.
- R6: A write pulse while halted loads the index with `wr_data_i` and reloads the SOF number to bits [13:3] of (`wr_data_i` − 1). A write while running has no effect.
- R7: Ticks while halted are ignored: no SOF request is raised and the index is unchanged.
- R8: The state machine has two states, HALTED and RUNNING. HALTED→RUNNING (start) when `run_en_i` is 1 at a clock edge; RUNNING→HALTED (stop) when it is 0. A tick counts only if the state was RUNNING before that edge, so a tick in the same cycle that `run_en_i` first rises is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en_i | input | 1 | 1 = run, 0 = halt |
| uf_tick_i | input | 1 | One-cycle 125 us microframe tick |
| wr_en_i | input | 1 | Software write strobe for the index |
| wr_data_i | input | 14 | Value to load into the index |
| idx_o | output | 14 | Current frame index |
| list_off_o | output | 12 | Byte offset into the periodic frame list |
| sof_num_o | output | 11 | Frame number for the SOF token |
| sof_req_o | output | 1 | One-cycle SOF request |

## Verification
The two counts are tied to each other, so a corrupt index or lag register breaks the R4 relation at the ports. That break is visible in the first cycle after the faulty update; it does not wait for a frame wrap. A wrong state shows up one tick later, either as a SOF pulse while halted or as a write that lands while running. The vectors aim at microframe wraps and at the 14-bit rollover, where a carry error between the two counts would surface.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
    typedef enum logic [0:0] {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/mfi_ctrl.sv
module mfi_ctrl
    import mfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en_i,
    input  logic uf_tick_i,
    input  logic wr_en_i,
    output logic step_o,
    output logic load_o
);
    run_state_e state_q, state_d;

    // next-state logic: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED:  if (run_en_i)  state_d = ST_RUNNING;
            ST_RUNNING: if (!run_en_i) state_d = ST_HALTED;
            default:                   state_d = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        step_o = 1'b0;
        load_o = 1'b0;
        unique case (state_q)
            ST_HALTED:  load_o = wr_en_i;
            ST_RUNNING: step_o = uf_tick_i;
            default: begin
                step_o = 1'b0;
                load_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mfi_index_reg.sv
module mfi_index_reg #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [IDX_W-1:0] wr_data_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (load_i) idx_q <= wr_data_i;
        else if (step_i) idx_q <= idx_q + 1'b1;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/mfi_sof_gen.sv
module mfi_sof_gen #(
    parameter int IDX_W = 14,
    parameter int UF_W  = 3,
    localparam int FRM_W = IDX_W - UF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [IDX_W-1:0] wr_data_i,
    input  logic [FRM_W-1:0] cur_frm_i,
    output logic [FRM_W-1:0] sof_num_o,
    output logic             sof_req_o
);
    logic [FRM_W-1:0] lag_q;
    logic             req_q;
    logic             wr_uf_zero;
    logic [FRM_W-1:0] wr_frm_m1;

    // frame field of (wr_data - 1): borrow only when microframe bits are zero
    assign wr_uf_zero = (wr_data_i[UF_W-1:0] == '0);
    assign wr_frm_m1  = wr_data_i[IDX_W-1:UF_W] - {{(FRM_W-1){1'b0}}, wr_uf_zero};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag_q <= '1;
            req_q <= 1'b0;
        end else begin
            req_q <= step_i;
            if (load_i)      lag_q <= wr_frm_m1;
            else if (step_i) lag_q <= cur_frm_i;
        end
    end

    assign sof_num_o = lag_q;
    assign sof_req_o = req_q;
endmodule

// File: rtl/mfi_counter_top.sv
module mfi_counter_top #(
    parameter int IDX_W     = 14,
    parameter int UF_W      = 3,
    parameter int LIST_AW   = 10,
    parameter int ENTRY_LG2 = 2,
    localparam int FRM_W = IDX_W - UF_W,
    localparam int OFF_W = LIST_AW + ENTRY_LG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic             uf_tick_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_data_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [OFF_W-1:0] list_off_o,
    output logic [FRM_W-1:0] sof_num_o,
    output logic             sof_req_o
);
    logic step_w;
    logic load_w;

    mfi_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en_i  (run_en_i),
        .uf_tick_i (uf_tick_i),
        .wr_en_i   (wr_en_i),
        .step_o    (step_w),
        .load_o    (load_w)
    );

    mfi_index_reg #(.IDX_W(IDX_W)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_w),
        .load_i    (load_w),
        .wr_data_i (wr_data_i),
        .idx_o     (idx_o)
    );

    mfi_sof_gen #(.IDX_W(IDX_W), .UF_W(UF_W)) u_sof (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_w),
        .load_i    (load_w),
        .wr_data_i (wr_data_i),
        .cur_frm_i (idx_o[IDX_W-1:UF_W]),
        .sof_num_o (sof_num_o),
        .sof_req_o (sof_req_o)
    );

    generate
        if (ENTRY_LG2 > 0) begin : g_scaled
            assign list_off_o = {idx_o[UF_W+LIST_AW-1:UF_W], {ENTRY_LG2{1'b0}}};
        end else begin : g_unscaled
            assign list_off_o = idx_o[UF_W+LIST_AW-1:UF_W];
        end
    endgenerate
endmodule

// File: rtl/mfi_counter_chk.sv
module mfi_counter_chk #(
    parameter int IDX_W = 14,
    parameter int UF_W  = 3,
    parameter int OFF_W = 12,
    localparam int FRM_W = IDX_W - UF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en_i,
    input logic             wr_en_i,
    input logic [IDX_W-1:0] idx_o,
    input logic [OFF_W-1:0] list_off_o,
    input logic [FRM_W-1:0] sof_num_o,
    input logic             sof_req_o
);
    logic [FRM_W-1:0] exp_lag;
    assign exp_lag = idx_o[IDX_W-1:UF_W]
                   - {{(FRM_W-1){1'b0}}, (idx_o[UF_W-1:0] == '0)};

    p_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_num_o == exp_lag);

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_req_o |-> (idx_o == IDX_W'($past(idx_o) + 1'b1)));

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_req_o |-> (sof_num_o == $past(idx_o[IDX_W-1:UF_W])));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(idx_o)) |-> (sof_req_o || $past(wr_en_i)));

    p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(list_off_o)) |-> ((idx_o[UF_W-1:0] == '0) || $past(wr_en_i)));

    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sof_req_o |-> $past(run_en_i, 2));
endmodule

bind mfi_counter_top mfi_counter_chk #(
    .IDX_W(IDX_W), .UF_W(UF_W), .OFF_W(OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en_i   (run_en_i),
    .wr_en_i    (wr_en_i),
    .idx_o      (idx_o),
    .list_off_o (list_off_o),
    .sof_num_o  (sof_num_o),
    .sof_req_o  (sof_req_o)
);

// File: tb/sim_mfi_counter_top.sv
module sim_mfi_counter_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int V_W [NV] = '{'h0000, 'h0007, 'h0008, 'h3FFF, 'h1FFF, 'h0FF8, 'h0123, 'h3FF0};
    localparam int V_N [NV] = '{1, 1, 1, 1, 2, 3, 5, 16};
    localparam int V_I [NV] = '{'h0001, 'h0008, 'h0009, 'h0000, 'h2001, 'h0FFB, 'h0128, 'h0000};
    localparam int V_S [NV] = '{'h000, 'h000, 'h001, 'h7FF, 'h400, 'h1FF, 'h024, 'h7FF};
    localparam int V_O [NV] = '{'h000, 'h004, 'h004, 'h000, 'h000, 'h7FC, 'h094, 'h000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [13:0] wr_data = '0;
    logic [13:0] idx;
    logic [11:0] off;
    logic [10:0] sof_num;
    logic        sof_req;

    int n_chk = 0;
    int n_bad = 0;

    mfi_counter_top u0 (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .uf_tick_i(tick),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .idx_o(idx), .list_off_o(off),
        .sof_num_o(sof_num), .sof_req_o(sof_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic do_write(input int v);
        @(negedge clk); wr_en = 1'b1; wr_data = 14'(v);
        cyc();
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_run(input logic r);
        @(negedge clk); run_en = r;
        cyc();
    endtask

    // one tick; returns pulse seen after edge and pulse one cycle later
    task automatic do_tick(output logic p0, output logic p1);
        @(negedge clk); tick = 1'b1;
        cyc(); p0 = sof_req;
        @(negedge clk); tick = 1'b0;
        cyc(); p1 = sof_req;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic p0, p1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 idx", int'(idx), 0);
        chk("R1 sof_num", int'(sof_num), 'h7FF);
        chk("R1 sof_req", int'(sof_req), 0);
        chk("R5 offset at reset", int'(off), 0);

        // vector table: write while halted, run, tick n times, halt, compare
        for (int v = 0; v < NV; v++) begin
            do_write(V_W[v]);
            set_run(1'b1);
            for (int t = 0; t < V_N[v]; t++) begin
                do_tick(p0, p1);
                chk("R3 pulse on tick", int'(p0), 1);
                chk("R3 pulse one cycle", int'(p1), 0);
            end
            set_run(1'b0);
            chk("R2 idx vector", int'(idx), V_I[v]);
            chk("R4 sof_num vector", int'(sof_num), V_S[v]);
            chk("R5 offset vector", int'(off), V_O[v]);
        end

        // R6 write loads lagged SOF value
        do_write('h0010);
        chk("R6 write idx", int'(idx), 'h10);
        chk("R6 write sof lag", int'(sof_num), 'h001);

        // R7 tick while halted ignored
        do_tick(p0, p1);
        chk("R7 no pulse halted", int'(p0), 0);
        chk("R7 idx unchanged", int'(idx), 'h10);

        // R6 write while running ignored
        set_run(1'b1);
        do_write('h2222);
        chk("R6 write ignored while running", int'(idx), 'h10);
        chk("R6 sof unchanged while running", int'(sof_num), 'h001);

        // R8 tick in the cycle run first rises is ignored
        set_run(1'b0);
        @(negedge clk); run_en = 1'b1; tick = 1'b1;
        cyc();
        chk("R8 first-cycle tick ignored", int'(sof_req), 0);
        @(negedge clk); tick = 1'b0;
        do_tick(p0, p1);
        chk("R8 later tick accepted", int'(p0), 1);
        chk("R2 idx after start", int'(idx), 'h11);
        chk("R4 sof after start", int'(sof_num), 'h002);

        // R8 stop: tick in cycle run drops still counts (state RUNNING before edge)
        @(negedge clk); run_en = 1'b0; tick = 1'b1;
        cyc();
        chk("R8 tick on stop edge counts", int'(sof_req), 1);
        @(negedge clk); tick = 1'b0;
        cyc();
        do_tick(p0, p1);
        chk("R8 halted after stop", int'(p0), 0);
        chk("R2 idx after stop", int'(idx), 'h12);

        // R1 reset mid-run
        set_run(1'b1);
        @(negedge clk); rst_n = 1'b0;
        cyc();
        @(negedge clk); rst_n = 1'b1; run_en = 1'b0;
        #1;
        chk("R1 idx after reset", int'(idx), 0);
        chk("R1 sof after reset", int'(sof_num), 'h7FF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule